// File: doc/BRIEF.md
# Data-Dependent Latency Word Multiplier

This block multiplies two 16-bit operands and returns the full 32-bit product. It has two modes: unsigned, where both operands are zero-extended, and signed, where both are two's complement. Its completion time is not fixed. It depends on the bit pattern of one operand, the timing source `src_a`, and follows the multiply timing of a classic microprocessor for a register operand.

Every operation takes a base of 38 clocks plus 2 clocks for each counted bit of `src_a`. Only the low 15 bit positions of `src_a` are scanned.
- In unsigned mode, each set bit is counted.
- In signed mode, each position where a bit differs from the bit below it is counted, as a Booth recoder would mark it. The position below bit 0 is taken as 0.

The product itself comes from a shift-add datapath that works on operand magnitudes. It finishes well inside the shortest latency. A separate down-counter decides when the result is released. A host pulses `start` while the block is idle, then waits for the single-cycle `done` pulse. At that pulse the product and its zero and negative flags are valid. They stay held until the next operation is accepted.

Top module: `varlat_word_mul`

## Requirements
- R1: A `start` sampled high while `busy` is low is accepted. `busy` is high from the cycle after acceptance until `done` is asserted.
- R2: With `signed_mode` = 0, `product` equals the zero-extended 32-bit product of `src_a` and `src_b`.
- R3: With `signed_mode` = 1, `product` equals the 32-bit two's-complement product of `src_a` and `src_b`, including the case -32768 × -32768 = 0x40000000.
- R4: In unsigned mode, `done` is high in the cycle after the L-th rising clock edge following the accepting edge. L = 38 + 2·N, where N is the number of ones in `src_a[14:0]`; bit 15 is not counted.
- R5: In signed mode, N is the number of ones in `src_a[14:0]` XOR {`src_a[13:0]`, 1'b0}. L follows the same 38 + 2·N rule as R4.
- R6: `done` is high for exactly one cycle, and `busy` is low in that cycle. `product` and the flags are valid then and stay unchanged until the next accepted start.
- R7: A `start` while `busy` is high is ignored. The running operation keeps its operands and latency, and no further operation is launched.
- R8: When `done` is high, `prod_zero` is 1 exactly when `product` is 0, and `prod_neg` equals `product[31]`.
- R9: After a synchronous active-low reset, `busy`, `done`, `product`, `prod_zero` and `prod_neg` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a multiply; accepted only while idle |
| signed_mode | input | 1 | 1 = signed operands, 0 = unsigned operands |
| src_a | input | 16 | Timing source operand and multiplicand |
| src_b | input | 16 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 32 | 32-bit product, held after done |
| prod_zero | output | 1 | Product is zero |
| prod_neg | output | 1 | Most significant bit of product |

## Verification
The hardest situation to reach is a second `start` arriving mid-operation with different operands and a different mode. If that start were wrongly taken, it would shift the completion time or corrupt the product. The stimulus launches a long operation, then holds `start` high for several cycles with a conflicting request. The bench checks that latency and product still match the first request, and that no second operation follows. The latency extremes are reached with all-zero, all-one and alternating patterns in both modes. For example, `0xFFFF` gives the full 68 clocks unsigned but only 40 signed, and `0x5555` gives 68 signed.

// File: rtl/varlat_mul_pkg.sv
// Package: shared types for the variable-latency multiplier.
// Assumes nothing beyond IEEE 1800-2017 enums.
package varlat_mul_pkg;

    // Sequencer state
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/vlm_latency_calc.sv
// Module: vlm_latency_calc
// Computes total operation latency from the timing source operand.
// Unsigned mode marks set bits; signed mode marks positions whose bit
// differs from the one below (bit below position 0 taken as 0).
// Assumes SCAN_BITS < WIDTH. Purely combinational.
module vlm_latency_calc #(
    parameter int WIDTH     = 16,
    parameter int SCAN_BITS = 15,
    parameter int BASE_LAT  = 38,
    parameter int STEP_LAT  = 2,
    localparam int LAT_W    = $clog2(BASE_LAT + STEP_LAT * SCAN_BITS + 1),
    localparam int CNT_W    = $clog2(SCAN_BITS + 1)
) (
    input  logic [WIDTH-1:0] src,
    input  logic             signed_mode,
    output logic [LAT_W-1:0] lat_total
);

    logic [SCAN_BITS-1:0] marks;
    logic [CNT_W-1:0]     mark_cnt;

    // Per-position mark: plain bit or adjacent-bit transition
    for (genvar gi = 0; gi < SCAN_BITS; gi++) begin : g_mark
        if (gi == 0) begin : g_lsb
            assign marks[gi] = src[gi];
        end else begin : g_upper
            assign marks[gi] = signed_mode ? (src[gi] ^ src[gi-1]) : src[gi];
        end
    end

    // Population count of the marks
    always_comb begin
        mark_cnt = '0;
        for (int i = 0; i < SCAN_BITS; i++) begin
            mark_cnt = mark_cnt + CNT_W'(marks[i]);
        end
    end

    // Base plus per-mark increment
    always_comb begin
        lat_total = LAT_W'(BASE_LAT) + LAT_W'(STEP_LAT) * LAT_W'(mark_cnt);
    end

endmodule

// File: rtl/vlm_sequencer.sv
// Module: vlm_sequencer
// Accepts start while idle, counts down the supplied latency, then
// issues a one-cycle capture strobe and a registered done pulse.
// Assumes lat_total >= 1 (always true for BASE_LAT >= 1).
module vlm_sequencer
    import varlat_mul_pkg::*;
#(
    parameter int LAT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] lat_total,
    output logic             accept,
    output logic             capture,
    output logic             busy,
    output logic             done
);

    seq_state_t       state;
    logic [LAT_W-1:0] remain;

    // Accept only in idle; capture on the last counted edge
    always_comb begin
        accept  = (state == SEQ_IDLE) && start;
        capture = (state == SEQ_RUN) && (remain == LAT_W'(1));
    end

    // State, countdown and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            done <= capture;
            if (accept) begin
                state  <= SEQ_RUN;
                remain <= lat_total;
            end else if (state == SEQ_RUN) begin
                remain <= remain - LAT_W'(1);
                if (capture) begin
                    state <= SEQ_IDLE;
                end
            end
        end
    end

    assign busy = (state == SEQ_RUN);

endmodule

// File: rtl/vlm_shift_add.sv
// Module: vlm_shift_add
// Shift-add multiplier on operand magnitudes with a final sign fix.
// Needs WIDTH clocks after load; the caller must not capture earlier.
// Holds the captured product and flags until the next capture.
module vlm_shift_add #(
    parameter int WIDTH = 16,
    localparam int PW   = 2 * WIDTH,
    localparam int SW   = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             capture,
    input  logic             signed_mode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [PW-1:0]    product,
    output logic             prod_zero,
    output logic             prod_neg
);

    logic [PW-1:0]    mcand;
    logic [WIDTH-1:0] mplier;
    logic [PW-1:0]    acc;
    logic [SW-1:0]    step;
    logic             neg_res;
    logic [WIDTH-1:0] mag_a;
    logic [WIDTH-1:0] mag_b;
    logic [PW-1:0]    result;

    // Operand magnitudes (most negative value maps to 2^(WIDTH-1))
    always_comb begin
        mag_a = (signed_mode && op_a[WIDTH-1]) ? (~op_a + WIDTH'(1)) : op_a;
        mag_b = (signed_mode && op_b[WIDTH-1]) ? (~op_b + WIDTH'(1)) : op_b;
    end

    // Iterative accumulate of shifted multiplicand
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand   <= '0;
            mplier  <= '0;
            acc     <= '0;
            step    <= SW'(WIDTH);
            neg_res <= 1'b0;
        end else if (load) begin
            mcand   <= PW'(mag_a);
            mplier  <= mag_b;
            acc     <= '0;
            step    <= '0;
            neg_res <= signed_mode & (op_a[WIDTH-1] ^ op_b[WIDTH-1]);
        end else if (step != SW'(WIDTH)) begin
            if (mplier[0]) begin
                acc <= acc + mcand;
            end
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            step   <= step + SW'(1);
        end
    end

    // Sign fix of the magnitude product
    always_comb begin
        result = neg_res ? (~acc + PW'(1)) : acc;
    end

    // Output register with flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product   <= '0;
            prod_zero <= 1'b0;
            prod_neg  <= 1'b0;
        end else if (capture) begin
            product   <= result;
            prod_zero <= (result == '0);
            prod_neg  <= result[PW-1];
        end
    end

endmodule

// File: rtl/varlat_word_mul.sv
// Module: varlat_word_mul (top)
// Signed/unsigned word multiplier whose completion time depends on the
// bit pattern of src_a. Operands are latched at acceptance; the latency
// is computed from the live inputs in the accepting cycle.
// Assumes BASE_LAT > WIDTH so the datapath finishes before release.
module varlat_word_mul #(
    parameter int WIDTH     = 16,
    parameter int SCAN_BITS = 15,
    parameter int BASE_LAT  = 38,
    parameter int STEP_LAT  = 2,
    localparam int PW       = 2 * WIDTH,
    localparam int LAT_W    = $clog2(BASE_LAT + STEP_LAT * SCAN_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             signed_mode,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic             busy,
    output logic             done,
    output logic [PW-1:0]    product,
    output logic             prod_zero,
    output logic             prod_neg
);

    logic [LAT_W-1:0] lat_total;
    logic             accept;
    logic             capture;

    // Latency from the timing source operand
    vlm_latency_calc #(
        .WIDTH     (WIDTH),
        .SCAN_BITS (SCAN_BITS),
        .BASE_LAT  (BASE_LAT),
        .STEP_LAT  (STEP_LAT)
    ) u_lat (
        .src         (src_a),
        .signed_mode (signed_mode),
        .lat_total   (lat_total)
    );

    // Acceptance and countdown
    vlm_sequencer #(
        .LAT_W (LAT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .lat_total (lat_total),
        .accept    (accept),
        .capture   (capture),
        .busy      (busy),
        .done      (done)
    );

    // Product datapath
    vlm_shift_add #(
        .WIDTH (WIDTH)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .capture     (capture),
        .signed_mode (signed_mode),
        .op_a        (src_a),
        .op_b        (src_b),
        .product     (product),
        .prod_zero   (prod_zero),
        .prod_neg    (prod_neg)
    );

endmodule

// File: rtl/varlat_word_mul_chk.sv
// Module: varlat_word_mul_chk
// Port-level protocol checks for varlat_word_mul, bound to the top.
// A cycle counter measures each operation so the latency window is
// checked without deep $past.
module varlat_word_mul_chk #(
    parameter int WIDTH     = 16,
    parameter int SCAN_BITS = 15,
    parameter int BASE_LAT  = 38,
    parameter int STEP_LAT  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product,
    input logic               prod_zero,
    input logic               prod_neg
);

    localparam int MAX_LAT = BASE_LAT + STEP_LAT * SCAN_BITS;
    localparam int MW      = $clog2(MAX_LAT + 2) + 1;

    logic [MW-1:0] meas;

    // Edges elapsed since acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas <= '0;
        end else if (start && !busy) begin
            meas <= '0;
        end else if (busy) begin
            meas <= meas + MW'(1);
        end
    end

    // R1: accepted start raises busy next cycle
    a_r1_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4 / R5: completion inside the latency window with step granularity
    a_r4_latency_window: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(meas) >= BASE_LAT && int'(meas) <= MAX_LAT &&
                  ((int'(meas) - BASE_LAT) % STEP_LAT) == 0));

    // R6: done is a single-cycle pulse with busy low
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6 / R7: product does not move during a running operation
    a_r7_product_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(product));

    // R8: flags agree with the released product
    a_r8_flags: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (prod_zero == (product == '0)) && (prod_neg == product[2*WIDTH-1]));

endmodule

bind varlat_word_mul varlat_word_mul_chk #(
    .WIDTH     (WIDTH),
    .SCAN_BITS (SCAN_BITS),
    .BASE_LAT  (BASE_LAT),
    .STEP_LAT  (STEP_LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .product   (product),
    .prod_zero (prod_zero),
    .prod_neg  (prod_neg)
);

// File: tb/varlat_word_mul_test.sv
// Directed bench for varlat_word_mul.
module varlat_word_mul_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [15:0] src_a = '0;
    logic [15:0] src_b = '0;
    logic        busy;
    logic        done;
    logic [31:0] product;
    logic        prod_zero;
    logic        prod_neg;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    varlat_word_mul uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .src_a       (src_a),
        .src_b       (src_b),
        .busy        (busy),
        .done        (done),
        .product     (product),
        .prod_zero   (prod_zero),
        .prod_neg    (prod_neg)
    );

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired act=%0d exp<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    // Model latency from R4/R5
    function automatic int model_lat(input bit sm, input logic [15:0] a);
        int n = 0;
        for (int i = 0; i < 15; i++) begin
            if (i == 0) n += a[0];
            else n += sm ? int'(a[i] ^ a[i-1]) : int'(a[i]);
        end
        return 38 + 2 * n;
    endfunction

    function automatic logic [31:0] model_prod(input bit sm, input logic [15:0] a,
                                               input logic [15:0] b);
        logic signed [31:0] sa, sb;
        if (sm) begin
            sa = $signed({{16{a[15]}}, a});
            sb = $signed({{16{b[15]}}, b});
            return 32'(sa * sb);
        end
        return {16'b0, a} * {16'b0, b};
    endfunction

    // Launch one operation; returns measured latency (-1 on timeout)
    task automatic launch_and_wait(input bit sm, input logic [15:0] a,
                                   input logic [15:0] b, output int lat);
        @(negedge clk);
        signed_mode = sm; src_a = a; src_b = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after accept", busy, 1);
        lat = 0;
        while (!done) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat > 200) begin
                lat = -1;
                break;
            end
        end
    endtask

    task automatic run_op(input bit sm, input logic [15:0] a, input logic [15:0] b);
        int lat;
        logic [31:0] ep;
        launch_and_wait(sm, a, b, lat);
        ep = model_prod(sm, a, b);
        chk(lat == model_lat(sm, a), sm ? "R5 signed latency" : "R4 unsigned latency",
            lat, model_lat(sm, a));
        chk(product == ep, sm ? "R3 signed product" : "R2 unsigned product", product, ep);
        chk(busy == 1'b0, "R6 busy low at done", busy, 0);
        chk(prod_zero == (ep == 0) && prod_neg == ep[31], "R8 flags",
            {prod_zero, prod_neg}, {ep == 0, ep[31]});
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", done, 0);
    endtask

    task automatic test_reset();
        chk(!busy && !done && product == 0 && !prod_zero && !prod_neg,
            "R9 reset state", {busy, done, prod_zero, prod_neg, product}, 0);
    endtask

    task automatic test_unsigned_patterns();
        run_op(1'b0, 16'h0000, 16'h1234);
        run_op(1'b0, 16'hFFFF, 16'hFFFF);
        run_op(1'b0, 16'h5555, 16'h0003);
        run_op(1'b0, 16'hAAAA, 16'h8001);
        run_op(1'b0, 16'h8000, 16'h0002);
    endtask

    task automatic test_signed_patterns();
        run_op(1'b1, 16'h0000, 16'h7FFF);
        run_op(1'b1, 16'hFFFF, 16'h1234);
        run_op(1'b1, 16'h5555, 16'hFFFE);
        run_op(1'b1, 16'hAAAA, 16'h0005);
        run_op(1'b1, 16'h8000, 16'h8000);
        run_op(1'b1, 16'h8000, 16'h7FFF);
    endtask

    // R7: start while busy must not disturb the running operation
    task automatic test_start_while_busy();
        int lat;
        logic [31:0] ep;
        @(negedge clk);
        signed_mode = 1'b0; src_a = 16'h7FFF; src_b = 16'h0101; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (4) begin @(posedge clk); lat++; @(negedge clk); end
        signed_mode = 1'b1; src_a = 16'h0000; src_b = 16'hFFFF; start = 1'b1;
        repeat (3) begin @(posedge clk); lat++; @(negedge clk); end
        start = 1'b0;
        while (!done && lat < 200) begin @(posedge clk); lat++; @(negedge clk); end
        ep = model_prod(1'b0, 16'h7FFF, 16'h0101);
        chk(lat == model_lat(1'b0, 16'h7FFF), "R7 latency kept", lat, model_lat(1'b0, 16'h7FFF));
        chk(product == ep, "R7 product kept", product, ep);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R7 no extra launch", busy, 0);
    endtask

    // R6: product held after done until next accept
    task automatic test_hold();
        logic [31:0] ep;
        run_op(1'b1, 16'hFFFB, 16'h0003);
        ep = model_prod(1'b1, 16'hFFFB, 16'h0003);
        signed_mode = 1'b0; src_a = 16'h1111; src_b = 16'h2222;
        repeat (5) @(negedge clk);
        chk(product == ep && !done, "R6 product held", product, ep);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_unsigned_patterns();
        test_signed_patterns();
        test_start_while_busy();
        test_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule